// File: doc/BRIEF.md
# Cascadable Configuration Data Streamer

This block holds a configuration image in a register array and plays it out to an FPGA, one bit or one byte per rising edge of the configuration clock. While the chip enable is low and the combined output-enable/reset is high, an internal address pointer moves forward on each clock edge. The data lanes show the stored value at that address. In serial mode the bits of each byte leave most significant bit first on lane 0 alone. In parallel mode all eight lanes carry a whole byte.

Once the pointer has stepped past the last address, the block freezes and floats its lanes. It then pulls its cascade enable output low so that a second device, whose chip enable is driven by that output, can continue the stream on the shared lanes. Taking the output-enable/reset low returns everything to the start. Taking the chip enable high also returns the pointer to the start and puts the block in standby.

High impedance is modelled as a per-lane drive-enable vector. A lane that is not driven reads as zero. A simple write port preloads the array. It is meant to be used while the block is in standby.

Top module: `cfg_prom_stream`

## Requirements
- R1: While ce_n is low, oe_rst_n is high and the stream is not exhausted, each rising clock edge moves the pointer to the next address. The value for address N is on the lanes between the edge that brings the pointer to N and the following edge. Address 0 is shown as soon as the block becomes enabled, with no edge needed.
- R2: With par_mode = 1 each address is one stored byte. dout[7:0] equals that byte and dout_oe = 8'hFF. The last address is DEPTH-1.
- R3: With par_mode = 0 (the default) each address is one bit. Byte index = address / 8, and bit position = 7 - (address mod 8), so bytes go out MSB first. The bit appears on dout[0] with dout_oe = 8'h01, and dout[7:1] stays 0. The last address is DEPTH*8-1.
- R4: Whenever oe_rst_n is low, the pointer is cleared without waiting for a clock. Also dout_oe = 0, dout = 0 and ceo_n = 1.
- R5: Whenever ce_n is high, standby = 1, dout_oe = 0 and dout = 0, whatever the level of oe_rst_n. The pointer returns to address 0 on the next clock edge.
- R6: One clock edge after the last address has been shown, the stream is exhausted. ceo_n goes low, dout_oe and dout become 0, and further edges change nothing for as long as ce_n stays low and oe_rst_n stays high.
- R7: A low pulse on oe_rst_n clears the exhausted state. After oe_rst_n returns high, ceo_n stays high and the stream restarts at address 0.
- R8: ceo_n is low only while ce_n is low. Raising ce_n on an exhausted block forces ceo_n high.
- R9: A byte written through wr_en/wr_addr/wr_data during standby is the one streamed out from that address afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; pointer and array write on the rising edge |
| oe_rst_n | input | 1 | Active-low combined output enable and asynchronous pointer reset |
| ce_n | input | 1 | Active-low chip enable; high selects standby |
| par_mode | input | 1 | Output mode: 0 serial (one bit per clock), 1 parallel (one byte per clock) |
| wr_en | input | 1 | Array preload write strobe |
| wr_addr | input | $clog2(DEPTH) | Array preload byte address |
| wr_data | input | 8 | Array preload byte |
| dout | output | 8 | Data lanes; 0 on every lane that is not driven |
| dout_oe | output | 8 | Per-lane drive enable; 0 models high impedance |
| ceo_n | output | 1 | Active-low cascade enable for the next device |
| standby | output | 1 | High while the chip enable is deasserted |

## Verification
The hardest state to reach from the ports is the exhausted condition in serial mode. It needs DEPTH*8 consecutive enabled edges with no reset, so the bench builds the block with a small array and sweeps every bit and every byte end to end. Expected lane values come from an arithmetic fill pattern. Once exhausted, the bench clocks on to prove the freeze. It then leaves that state in both legal ways, a chip-enable release and a reset pulse, and checks that the second pass really starts at address 0. A reset pulse in the middle of a stream checks the asynchronous clear between clock edges.

// File: rtl/cfg_prom_pkg.sv
package cfg_prom_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {
      MODE_SER = 1'b0,
      MODE_PAR = 1'b1
   } prom_mode_e;
endpackage

// File: rtl/cfg_prom_array.sv
module cfg_prom_array #(
   parameter int DEPTH = 256,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                             clk,
   input  logic                             wr_en,
   input  logic [AW-1:0]                    wr_addr,
   input  logic [cfg_prom_pkg::BYTE_W-1:0]  wr_data,
   input  logic [AW-1:0]                    rd_idx,
   output logic [cfg_prom_pkg::BYTE_W-1:0]  rd_byte
);
   logic [cfg_prom_pkg::BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_addr) < DEPTH)) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/cfg_prom_addr.sv
module cfg_prom_addr
   import cfg_prom_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int CW = $clog2(DEPTH * BYTE_W)
) (
   input  logic          clk,
   input  logic          oe_rst_n,
   input  logic          ce_n,
   input  prom_mode_e    mode,
   output logic [CW-1:0] addr,
   output logic          spent
);
   localparam logic [CW-1:0] LAST_SER = CW'(DEPTH * BYTE_W - 1);
   localparam logic [CW-1:0] LAST_PAR = CW'(DEPTH - 1);

   logic [CW-1:0] last_addr;
   assign last_addr = (mode == MODE_PAR) ? LAST_PAR : LAST_SER;

   always_ff @(posedge clk or negedge oe_rst_n) begin
      if (!oe_rst_n) begin
         addr  <= '0;
         spent <= 1'b0;
      end else if (ce_n) begin
         addr  <= '0;
         spent <= 1'b0;
      end else if (!spent) begin
         if (addr == last_addr) begin
            spent <= 1'b1;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

   // R5
   hold_idle_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
      ce_n |=> (addr == '0) && !spent);

   // R1
   step_fwd_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
      (!ce_n && !spent && addr != last_addr) |=> (addr == $past(addr) + 1'b1));

   // R6
   freeze_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
      (!ce_n && spent) |=> spent && $stable(addr));
endmodule

// File: rtl/cfg_prom_stream.sv
module cfg_prom_stream
   import cfg_prom_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter bit PAR_EN = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH * BYTE_W)
) (
   input  logic              clk,
   input  logic              oe_rst_n,
   input  logic              ce_n,
   input  logic              par_mode,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] dout,
   output logic [BYTE_W-1:0] dout_oe,
   output logic              ceo_n,
   output logic              standby
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cfg_prom_stream: DEPTH must be a power of two, at least 2");
   end

   prom_mode_e mode_eff;
   if (PAR_EN) begin : g_dual_mode
      assign mode_eff = par_mode ? MODE_PAR : MODE_SER;
   end else begin : g_serial_only
      assign mode_eff = MODE_SER;
   end

   logic          is_par;
   logic [CW-1:0] addr;
   logic          spent;
   logic [AW-1:0] byte_idx;
   logic [2:0]    bit_sel;
   logic [BYTE_W-1:0] rd_byte;
   logic          ser_bit;
   logic          drive;
   logic [BYTE_W-1:0] lane_oe;
   logic [BYTE_W-1:0] lane_val;

   assign is_par = (mode_eff == MODE_PAR);

   cfg_prom_addr #(.DEPTH(DEPTH)) u_addr (
      .clk      (clk),
      .oe_rst_n (oe_rst_n),
      .ce_n     (ce_n),
      .mode     (mode_eff),
      .addr     (addr),
      .spent    (spent)
   );

   assign byte_idx = is_par ? addr[AW-1:0] : addr[CW-1:3];
   assign bit_sel  = addr[2:0];

   cfg_prom_array #(.DEPTH(DEPTH)) u_array (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_idx  (byte_idx),
      .rd_byte (rd_byte)
   );

   assign ser_bit = rd_byte[3'd7 - bit_sel];
   assign drive   = oe_rst_n && !ce_n && !spent;

   for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
      if (i == 0) begin : g_lsb
         assign lane_oe[i]  = drive;
         assign lane_val[i] = is_par ? rd_byte[0] : ser_bit;
      end else begin : g_upper
         assign lane_oe[i]  = drive && is_par;
         assign lane_val[i] = rd_byte[i];
      end
   end

   assign dout_oe = lane_oe;
   assign dout    = lane_val & lane_oe;
   assign ceo_n   = !(oe_rst_n && !ce_n && spent);
   assign standby = ce_n;

   // R4
   always @(posedge clk) begin
      if (!oe_rst_n) begin
         rst_quiet_chk: assert (ceo_n && dout_oe == '0 && dout == '0);
      end
   end

   // R6
   spent_float_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
      !ceo_n |-> (dout_oe == '0));

   // R3
   ser_lane_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
      (mode_eff == MODE_SER) |-> (dout_oe[BYTE_W-1:1] == '0 && dout[BYTE_W-1:1] == '0));

   // R8
   standby_ceo_chk: assert property (@(posedge clk) disable iff (!oe_rst_n)
      ce_n |-> (ceo_n && standby && dout_oe == '0));
endmodule

// File: tb/cfg_prom_stream_tb.sv
`timescale 1ns/1ps
module cfg_prom_stream_tb;
   localparam int D  = 16;
   localparam int AW = $clog2(D);

   logic          clk = 1'b0;
   logic          oe_rst_n, ce_n, par_mode, wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic [7:0]    dout, dout_oe;
   logic          ceo_n, standby;

   logic [7:0] ref_mem [D];
   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cfg_prom_stream #(.DEPTH(D), .PAR_EN(1'b1)) u_dut (
      .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce_n), .par_mode(par_mode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dout(dout), .dout_oe(dout_oe), .ceo_n(ceo_n), .standby(standby)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   function automatic logic [7:0] pattern(input int i);
      return 8'((i * 37 + 11) ^ (i << 4));
   endfunction

   task automatic write_byte(input int a, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      ref_mem[a] = v;
   endtask

   // Caller has just enabled the block at a falling edge; the pointer is at 0.
   task automatic run_stream(input bit par);
      int n;
      logic [7:0] eb;
      n = par ? D : D * 8;
      for (int k = 0; k < n; k++) begin
         #1;
         if (par) begin
            eb = ref_mem[k];
            chk(dout == eb && dout_oe == 8'hFF, "R2 R1 parallel byte", {dout_oe, dout}, {8'hFF, eb});
         end else begin
            eb = {7'b0, ref_mem[k / 8][7 - (k % 8)]};
            chk(dout == eb && dout_oe == 8'h01, "R3 R1 serial bit", {dout_oe, dout}, {8'h01, eb});
         end
         chk(ceo_n == 1'b1, "R6 ceo_n high before end", 32'(ceo_n), 32'd1);
         @(negedge clk);
      end
      #1;
      chk(ceo_n == 1'b0 && dout_oe == 8'h00 && dout == 8'h00, "R6 exhausted",
          {ceo_n, dout_oe, dout}, 32'h0);
      repeat (3) @(negedge clk);
      #1;
      chk(ceo_n == 1'b0 && dout_oe == 8'h00, "R6 frozen after extra edges",
          {ceo_n, dout_oe}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      oe_rst_n = 1'b0; ce_n = 1'b1; par_mode = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      @(negedge clk); #1;
      chk(dout_oe == 8'h00 && dout == 8'h00 && ceo_n && standby, "R4 R5 reset state",
          {standby, ceo_n, dout_oe, dout}, {1'b1, 1'b1, 16'h0});

      for (int i = 0; i < D; i++) write_byte(i, pattern(i));

      @(negedge clk); oe_rst_n = 1'b1; #1;
      chk(standby && dout_oe == 8'h00 && ceo_n, "R5 standby with oe high",
          {standby, ceo_n, dout_oe}, {1'b1, 1'b1, 8'h00});

      // full serial sweep
      @(negedge clk); ce_n = 1'b0;
      run_stream(1'b0);

      // chip enable release on exhausted block
      @(negedge clk); ce_n = 1'b1; #1;
      chk(ceo_n && standby && dout_oe == 8'h00, "R8 ce high clears ceo",
          {ceo_n, standby, dout_oe}, {1'b1, 1'b1, 8'h00});
      @(negedge clk); ce_n = 1'b0; #1;
      chk(dout_oe == 8'h01 && dout == {7'b0, ref_mem[0][7]}, "R5 restart at address 0",
          {dout_oe, dout}, {8'h01, 7'b0, ref_mem[0][7]});

      // reset pulse in the middle of a stream
      repeat (5) @(negedge clk);
      #1;
      chk(dout == {7'b0, ref_mem[0][2]}, "R1 serial address 5", dout, {7'b0, ref_mem[0][2]});
      oe_rst_n = 1'b0; #1;
      chk(dout_oe == 8'h00 && dout == 8'h00 && ceo_n, "R4 async float",
          {ceo_n, dout_oe, dout}, {1'b1, 16'h0});
      repeat (2) @(negedge clk);
      #1;
      chk(dout_oe == 8'h00 && ceo_n, "R4 held in reset", {ceo_n, dout_oe}, {1'b1, 8'h00});
      @(negedge clk); oe_rst_n = 1'b1;
      run_stream(1'b0);

      // reset pulse after exhaustion
      @(negedge clk); oe_rst_n = 1'b0; #1;
      chk(ceo_n == 1'b1, "R7 ceo high during reset", 32'(ceo_n), 32'd1);
      @(negedge clk); oe_rst_n = 1'b1; #1;
      chk(ceo_n && dout_oe == 8'h01 && dout == {7'b0, ref_mem[0][7]}, "R7 restart after reset",
          {ceo_n, dout_oe, dout}, {1'b1, 8'h01, 7'b0, ref_mem[0][7]});

      // parallel sweep
      @(negedge clk); ce_n = 1'b1;
      @(negedge clk); par_mode = 1'b1; ce_n = 1'b0;
      run_stream(1'b1);

      // preload overwrite, then re-stream
      @(negedge clk); ce_n = 1'b1;
      write_byte(3, ~pattern(3));
      write_byte(D - 1, 8'hA5);
      @(negedge clk); ce_n = 1'b0; #1;
      chk(dout == ref_mem[0], "R9 parallel address 0 after writes", dout, ref_mem[0]);
      repeat (3) @(negedge clk);
      #1;
      chk(dout == 8'(~pattern(3)), "R9 rewritten byte", dout, 8'(~pattern(3)));
      @(negedge clk); ce_n = 1'b1;
      @(negedge clk); ce_n = 1'b0;
      run_stream(1'b1);

      // both controls inactive
      @(negedge clk); oe_rst_n = 1'b0; ce_n = 1'b1; #1;
      chk(standby && ceo_n && dout_oe == 8'h00 && dout == 8'h00, "R5 R4 reset with standby",
          {standby, ceo_n, dout_oe, dout}, {1'b1, 1'b1, 16'h0});

      finish_up();
   end
endmodule